// File: doc/BRIEF.md
# NAND Block Health Checker and Retirement Marker

This controller answers one question about a NAND flash block (is it bad?) and performs one action on it (retire it by writing a bad marker). It does not touch the flash pins. It drives a single command port toward the lower sequencers that load pages into the device cache, read cached bytes, erase blocks, stage program data and execute programs. Each command completes with a one-cycle response that carries an error code and, for reads, a data byte.

A check loads a page and reads the first spare byte, which sits right after the data area. A value other than the erased pattern 0xFF means the block is bad. When the requested row is the first page of its block and that page reads clean, the following page is examined as well. Only when both are clean is the block reported good. A mark erases the block, stages the value 0xF0 at the marker column and executes a program to the block's first page. Any nonzero error code from a sequencer ends the operation at once and is reported unchanged.

Top module: `nand_badblk_ctrl`

## Requirements
- R1: A check issues a page load (op 0) for the requested row, then a byte read (op 1) at column DATA_BYTES (0x800 by default). The block is reported bad when the returned byte differs from 0xFF.
- R2: When the requested row is a block's first page (row modulo PAGES_PER_BLK is 0) and its marker reads 0xFF, the next row (row+1) is loaded and read the same way. bad_o is 0 only if both markers are 0xFF.
- R3: When the requested row is not a block's first page, only that row is loaded and read.
- R4: When the first page's marker is not 0xFF, no second load is issued.
- R5: A mark issues an erase (op 2), a program-data load (op 3) of byte 0xF0 at column DATA_BYTES, and a program execute (op 4), in that order. The erase and the execute use the block's first page (the row with its low log2(PAGES_PER_BLK) bits cleared). Success reports bad_o=1 and err_o=0.
- R6: If the erase response carries a nonzero error, no program-data load and no program execute follow. err_o carries the erase error code.
- R7: A nonzero error code on any response aborts the operation at once. err_o equals that code unchanged and bad_o is 0.
- R8: A request is taken only while busy_o is 0. A check and a mark asserted in the same cycle are both ignored, and requests made while busy are ignored.
- R9: cmd_req_o stays high, with op, row, column and data stable, until the cycle in which rsp_done_i is 1. cmd_row_o carries the row as three bytes, bits 23:16, 15:8 and 7:0.
- R10: After reset busy_o, done_o, bad_o, err_o and cmd_req_o are 0. done_o is a one-cycle pulse in the cycle after the final response. bad_o and err_o hold their values until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_req_i | input | 1 | Request a bad-block check |
| mark_req_i | input | 1 | Request a bad-block mark |
| row_i | input | ROW_W | Row (page) address of the request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bad_o | output | 1 | Block bad (check) or marked (mark) |
| err_o | output | ERR_W | Error code passed through, 0 when none |
| cmd_req_o | output | 1 | Command to sequencers valid |
| cmd_op_o | output | 3 | 0 load page, 1 read byte, 2 erase, 3 program-data load, 4 program execute |
| cmd_row_o | output | ROW_W | Row address for the command |
| cmd_col_o | output | COL_W | Column address for read and program-data load |
| cmd_data_o | output | 8 | Byte for program-data load |
| rsp_done_i | input | 1 | Command completed (one cycle) |
| rsp_err_i | input | ERR_W | Completion error code, 0 means success |
| rsp_data_i | input | 8 | Byte returned by a read |

## Verification
The bench models the sequencers with a fixed latency L. Each command therefore lasts exactly L+1 clock edges, and done_o is due n·(L+1) edges after the accepting edge, where n is the number of commands the requirement predicts: 2 or 4 for a check, 3 for a mark, and fewer on an abort. The bench counts falling edges from the accept and compares that count with the predicted one. It samples bad_o and err_o in the same falling-edge window in which done_o is first seen. It also compares the command counts per opcode, the rows the model saw, and the model's stored markers against values it computes itself.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_LOAD  = 3'd0;
  localparam logic [OP_W-1:0] OP_READ  = 3'd1;
  localparam logic [OP_W-1:0] OP_ERASE = 3'd2;
  localparam logic [OP_W-1:0] OP_PLOAD = 3'd3;
  localparam logic [OP_W-1:0] OP_PEXEC = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_READ,
    ST_ERASE,
    ST_PLOAD,
    ST_PEXEC
  } state_e;
endpackage

// File: rtl/bbm_row_calc.sv
module bbm_row_calc #(
  parameter int ROW_W         = 24,
  parameter int PAGES_PER_BLK = 64
) (
  input  logic [ROW_W-1:0] row_i,
  output logic [ROW_W-1:0] first_o,
  output logic [ROW_W-1:0] next_o,
  output logic             is_first_o
);
  localparam int PG_W = $clog2(PAGES_PER_BLK);

  // power-of-two block size: modulo reduces to the low page bits
  generate
    if (PG_W == 0) begin : g_one_page
      assign first_o    = row_i;
      assign is_first_o = 1'b1;
    end else begin : g_multi_page
      assign first_o    = {row_i[ROW_W-1:PG_W], {PG_W{1'b0}}};
      assign is_first_o = (row_i[PG_W-1:0] == '0);
    end
  endgenerate

  assign next_o = row_i + ROW_W'(1);
endmodule

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
#(
  parameter int          ROW_W         = 24,
  parameter int          COL_W         = 12,
  parameter int          ERR_W         = 4,
  parameter int          PAGES_PER_BLK = 64,
  parameter int          DATA_BYTES    = 2048,
  parameter logic [7:0]  MARK_VAL      = 8'hF0,
  parameter logic [7:0]  ERASED_VAL    = 8'hFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chk_req_i,
  input  logic             mark_req_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             busy_o,
  output logic             cmd_req_o,
  output logic [OP_W-1:0]  cmd_op_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic [7:0]       cmd_data_o,
  input  logic             rsp_done_i,
  input  logic [ERR_W-1:0] rsp_err_i,
  input  logic [7:0]       rsp_data_i,
  output logic             start_o,
  output logic             fin_o,
  output logic             fin_bad_o,
  output logic [ERR_W-1:0] fin_err_o
);
  state_e           state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             second_q, second_d;
  logic [ROW_W-1:0] blk_first, row_next;
  logic             row_is_first;
  logic             rsp_fail;

  bbm_row_calc #(
    .ROW_W        (ROW_W),
    .PAGES_PER_BLK(PAGES_PER_BLK)
  ) u_row_calc (
    .row_i     (row_q),
    .first_o   (blk_first),
    .next_o    (row_next),
    .is_first_o(row_is_first)
  );

  assign rsp_fail = rsp_done_i && (rsp_err_i != '0);
  assign busy_o   = (state_q != ST_IDLE);

  always_comb begin
    state_d    = state_q;
    row_d      = row_q;
    second_d   = second_q;
    start_o    = 1'b0;
    fin_o      = 1'b0;
    fin_bad_o  = 1'b0;
    fin_err_o  = '0;
    cmd_req_o  = (state_q != ST_IDLE);
    cmd_op_o   = OP_LOAD;
    cmd_row_o  = row_q;
    cmd_col_o  = COL_W'(DATA_BYTES);
    cmd_data_o = MARK_VAL;
    unique case (state_q)
      ST_IDLE: begin
        // simultaneous check and mark: neither taken
        if (chk_req_i ^ mark_req_i) begin
          start_o  = 1'b1;
          row_d    = row_i;
          second_d = 1'b0;
          state_d  = chk_req_i ? ST_LOAD : ST_ERASE;
        end
      end
      ST_LOAD: begin
        cmd_op_o = OP_LOAD;
        if (rsp_done_i) state_d = ST_READ;
      end
      ST_READ: begin
        cmd_op_o = OP_READ;
        if (rsp_done_i) begin
          if (rsp_data_i != ERASED_VAL) begin
            fin_o     = 1'b1;
            fin_bad_o = 1'b1;
            state_d   = ST_IDLE;
          end else if (!second_q && row_is_first) begin
            row_d    = row_next;
            second_d = 1'b1;
            state_d  = ST_LOAD;
          end else begin
            fin_o   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_ERASE: begin
        cmd_op_o  = OP_ERASE;
        cmd_row_o = blk_first;
        if (rsp_done_i) state_d = ST_PLOAD;
      end
      ST_PLOAD: begin
        cmd_op_o  = OP_PLOAD;
        cmd_row_o = blk_first;
        if (rsp_done_i) state_d = ST_PEXEC;
      end
      ST_PEXEC: begin
        cmd_op_o  = OP_PEXEC;
        cmd_row_o = blk_first;
        if (rsp_done_i) begin
          fin_o     = 1'b1;
          fin_bad_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    // any sub-sequencer error aborts with its code
    if (cmd_req_o && rsp_fail) begin
      fin_o     = 1'b1;
      fin_bad_o = 1'b0;
      fin_err_o = rsp_err_i;
      row_d     = row_q;
      second_d  = second_q;
      state_d   = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      second_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      row_q    <= row_d;
      second_q <= second_d;
    end
  end

  assert_cmd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && !rsp_done_i) |=> (cmd_req_o && $stable(cmd_op_o) && $stable(cmd_row_o)
                                    && $stable(cmd_col_o) && $stable(cmd_data_o)));

  assert_pexec_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && cmd_op_o == OP_PEXEC) |-> ((cmd_row_o & ROW_W'(PAGES_PER_BLK - 1)) == '0));
endmodule

// File: rtl/bbm_result.sv
module bbm_result #(
  parameter int ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fin_i,
  input  logic             fin_bad_i,
  input  logic [ERR_W-1:0] fin_err_i,
  output logic             done_o,
  output logic             bad_o,
  output logic [ERR_W-1:0] err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      bad_o  <= 1'b0;
      err_o  <= '0;
    end else begin
      done_o <= fin_i;
      if (fin_i) begin
        bad_o <= fin_bad_i;
        err_o <= fin_err_i;
      end else if (start_i) begin
        bad_o <= 1'b0;
        err_o <= '0;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/nand_badblk_ctrl.sv
module nand_badblk_ctrl
  import bbm_pkg::*;
#(
  parameter int         ROW_W         = 24,
  parameter int         ERR_W         = 4,
  parameter int         PAGES_PER_BLK = 64,
  parameter int         DATA_BYTES    = 2048,
  parameter logic [7:0] MARK_VAL      = 8'hF0,
  parameter logic [7:0] ERASED_VAL    = 8'hFF,
  localparam int        COL_W         = $clog2(DATA_BYTES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chk_req_i,
  input  logic             mark_req_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             bad_o,
  output logic [ERR_W-1:0] err_o,
  output logic             cmd_req_o,
  output logic [2:0]       cmd_op_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic [7:0]       cmd_data_o,
  input  logic             rsp_done_i,
  input  logic [ERR_W-1:0] rsp_err_i,
  input  logic [7:0]       rsp_data_i
);
  logic             start;
  logic             fin;
  logic             fin_bad;
  logic [ERR_W-1:0] fin_err;

  bbm_ctrl #(
    .ROW_W        (ROW_W),
    .COL_W        (COL_W),
    .ERR_W        (ERR_W),
    .PAGES_PER_BLK(PAGES_PER_BLK),
    .DATA_BYTES   (DATA_BYTES),
    .MARK_VAL     (MARK_VAL),
    .ERASED_VAL   (ERASED_VAL)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chk_req_i (chk_req_i),
    .mark_req_i(mark_req_i),
    .row_i     (row_i),
    .busy_o    (busy_o),
    .cmd_req_o (cmd_req_o),
    .cmd_op_o  (cmd_op_o),
    .cmd_row_o (cmd_row_o),
    .cmd_col_o (cmd_col_o),
    .cmd_data_o(cmd_data_o),
    .rsp_done_i(rsp_done_i),
    .rsp_err_i (rsp_err_i),
    .rsp_data_i(rsp_data_i),
    .start_o   (start),
    .fin_o     (fin),
    .fin_bad_o (fin_bad),
    .fin_err_o (fin_err)
  );

  bbm_result #(
    .ERR_W(ERR_W)
  ) u_result (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .fin_i    (fin),
    .fin_bad_i(fin_bad),
    .fin_err_i(fin_err),
    .done_o   (done_o),
    .bad_o    (bad_o),
    .err_o    (err_o)
  );

  assert_erase_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && cmd_op_o == OP_ERASE && rsp_done_i && rsp_err_i != '0)
      |=> (done_o && !cmd_req_o && err_o == $past(rsp_err_i)));

  assert_bad_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && bad_o) |-> (err_o == '0));

  assert_dual_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && chk_req_i && mark_req_i) |=> !busy_o);

  assert_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && chk_req_i && !mark_req_i) |=> (cmd_req_o && cmd_op_o == OP_LOAD));
endmodule

// File: tb/nand_badblk_ctrl_tb.sv
module nand_badblk_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PPB        = 4;
  localparam int NPG        = 32;
  localparam int LAT        = 2;
  localparam int COL_W      = 12;
  localparam logic [23:0] ROW_HI = 24'h5AC300;
  localparam logic [COL_W-1:0] MCOL = 12'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_req = 1'b0, mark_req = 1'b0;
  logic [23:0] row_in = '0;
  logic busy_o, done_o, bad_o;
  logic [3:0] err_o;
  logic cmd_req;
  logic [2:0] cmd_op;
  logic [23:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [7:0] cmd_data;
  logic rsp_done;
  logic [3:0] rsp_err;
  logic [7:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_badblk_ctrl #(.PAGES_PER_BLK(PPB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .chk_req_i(chk_req), .mark_req_i(mark_req),
    .row_i(row_in), .busy_o(busy_o), .done_o(done_o), .bad_o(bad_o), .err_o(err_o),
    .cmd_req_o(cmd_req), .cmd_op_o(cmd_op), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .cmd_data_o(cmd_data), .rsp_done_i(rsp_done), .rsp_err_i(rsp_err), .rsp_data_i(rsp_data)
  );

  // sequencer and flash model
  logic [7:0] mk [NPG];
  logic [4:0] cache_pg;
  logic [7:0] pbuf;
  logic [COL_W-1:0] pcol;
  int lcnt;
  int n_load, n_read, n_erase, n_pload, n_pexec;
  logic [23:0] last_load_row, last_erase_row, last_pexec_row;
  logic set_en = 1'b0;
  logic [4:0] set_idx = '0;
  logic [7:0] set_val = '0;
  logic [2:0] inj_op = 3'd0;
  logic [3:0] inj_code = 4'd0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPG; p++) mk[p] <= 8'hFF;
      cache_pg <= '0; pbuf <= 8'hFF; pcol <= '0; lcnt <= 0;
      n_load <= 0; n_read <= 0; n_erase <= 0; n_pload <= 0; n_pexec <= 0;
      last_load_row <= '0; last_erase_row <= '0; last_pexec_row <= '0;
      rsp_done <= 1'b0; rsp_err <= '0; rsp_data <= '0;
    end else begin
      if (set_en) mk[set_idx] <= set_val;
      if (cmd_req && !rsp_done) begin
        if (lcnt == LAT - 1) begin
          lcnt <= 0;
          rsp_done <= 1'b1;
          rsp_data <= 8'h00;
          rsp_err <= '0;
          case (cmd_op)
            3'd0: begin n_load <= n_load + 1; last_load_row <= cmd_row; end
            3'd1: n_read <= n_read + 1;
            3'd2: begin n_erase <= n_erase + 1; last_erase_row <= cmd_row; end
            3'd3: n_pload <= n_pload + 1;
            3'd4: begin n_pexec <= n_pexec + 1; last_pexec_row <= cmd_row; end
            default: ;
          endcase
          if (cmd_op == inj_op && inj_code != 4'd0) begin
            rsp_err <= inj_code;
          end else begin
            case (cmd_op)
              3'd0: cache_pg <= cmd_row[4:0];
              3'd1: rsp_data <= (cmd_col == MCOL) ? mk[cache_pg] : 8'h00;
              3'd2: for (int p = 0; p < PPB; p++) mk[{cmd_row[4:2], 2'(p)}] <= 8'hFF;
              3'd3: begin pbuf <= cmd_data; pcol <= cmd_col; end
              3'd4: if (pcol == MCOL) mk[cmd_row[4:0]] <= mk[cmd_row[4:0]] & pbuf;
              default: ;
            endcase
          end
        end else begin
          lcnt <= lcnt + 1;
        end
      end else begin
        rsp_done <= 1'b0;
      end
    end
  end

  int n_chk = 0, n_err = 0;
  int cyc;
  logic r_bad;
  logic [3:0] r_err;
  int d_load, d_read, d_erase, d_pload, d_pexec;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_mark(input int idx, input logic [7:0] val);
    @(negedge clk);
    set_en = 1'b1; set_idx = 5'(idx); set_val = val;
    @(negedge clk);
    set_en = 1'b0;
  endtask

  task automatic run(input bit mark, input logic [23:0] row, input bit poke);
    int s_l, s_r, s_e, s_pl, s_px;
    s_l = n_load; s_r = n_read; s_e = n_erase; s_pl = n_pload; s_px = n_pexec;
    @(negedge clk);
    chk_req = !mark; mark_req = mark; row_in = row;
    cyc = 0;
    forever begin
      @(negedge clk);
      chk_req = 1'b0; mark_req = 1'b0;
      cyc++;
      if (poke && cyc == 3) mark_req = 1'b1;
      if (done_o) break;
      if (cyc > 400) begin
        chk("R10", "done timeout", 0, 1);
        break;
      end
    end
    r_bad = bad_o; r_err = err_o;
    d_load = n_load - s_l; d_read = n_read - s_r; d_erase = n_erase - s_e;
    d_pload = n_pload - s_pl; d_pexec = n_pexec - s_px;
  endtask

  function automatic logic [7:0] vv(input int k);
    case (k)
      0: return 8'hFF;
      1: return 8'h00;
      2: return 8'hF0;
      default: return 8'h7F;
    endcase
  endfunction

  function automatic logic [23:0] mkrow(input int pg);
    return ROW_HI | 24'(pg);
  endfunction

  localparam int CMD_CYC = LAT + 1;

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "busy after reset", int'(busy_o), 0);
    chk("R10", "done after reset", int'(done_o), 0);
    chk("R10", "bad after reset", int'(bad_o), 0);
    chk("R10", "err after reset", int'(err_o), 0);
    chk("R10", "cmd_req after reset", int'(cmd_req), 0);

    // R1 R2 R3 R4: marker sweep on block 1 (pages 4..7)
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        set_mark(4, vv(i));
        set_mark(5, vv(j));
        set_mark(6, vv(i));
        run(1'b0, mkrow(4), 1'b0);
        begin
          int nl;
          nl = (vv(i) != 8'hFF) ? 1 : 2;
          chk("R2", "bad first-page check", int'(r_bad), int'(vv(i) != 8'hFF || vv(j) != 8'hFF));
          chk("R4", "loads first-page check", d_load, nl);
          chk("R1", "reads first-page check", d_read, nl);
          chk("R7", "err clean check", int'(r_err), 0);
          chk("R10", "cycles first-page check", cyc, 2 * nl * CMD_CYC + 1);
          chk("R2", "last load row", int'(last_load_row), int'(mkrow(nl == 2 ? 5 : 4)));
        end
        run(1'b0, mkrow(5), 1'b0);
        chk("R3", "bad mid-page check", int'(r_bad), int'(vv(j) != 8'hFF));
        chk("R3", "loads mid-page check", d_load, 1);
        chk("R3", "cycles mid-page check", cyc, 2 * CMD_CYC + 1);
        run(1'b0, mkrow(6), 1'b0);
        chk("R1", "bad page-2 check", int'(r_bad), int'(vv(i) != 8'hFF));
        chk("R3", "loads page-2 check", d_load, 1);
      end
    end

    // R10 hold and pulse
    @(negedge clk);
    chk("R10", "done one cycle", int'(done_o), 0);
    repeat (4) @(negedge clk);
    chk("R10", "bad held", int'(bad_o), int'(r_bad));
    chk("R10", "err held", int'(err_o), int'(r_err));

    // R5 mark sweep over all blocks
    for (int b = 0; b < NPG / PPB; b++) begin
      set_mark(b * PPB, 8'h00);
      set_mark(b * PPB + 1, 8'h3C);
      run(1'b1, mkrow(b * PPB + (b % PPB)), 1'b0);
      chk("R5", "mark bad", int'(r_bad), 1);
      chk("R5", "mark err", int'(r_err), 0);
      chk("R5", "mark erase count", d_erase, 1);
      chk("R5", "mark pload count", d_pload, 1);
      chk("R5", "mark pexec count", d_pexec, 1);
      chk("R5", "mark load count", d_load, 0);
      chk("R5", "mark cycles", cyc, 3 * CMD_CYC + 1);
      chk("R5", "erase row", int'(last_erase_row), int'(mkrow(b * PPB)));
      chk("R5", "pexec row", int'(last_pexec_row), int'(mkrow(b * PPB)));
      chk("R5", "marker written", int'(mk[b * PPB]), 8'hF0);
      chk("R5", "next page erased", int'(mk[b * PPB + 1]), 8'hFF);
      run(1'b0, mkrow(b * PPB), 1'b0);
      chk("R5", "marked block reads bad", int'(r_bad), 1);
      chk("R4", "marked block single load", d_load, 1);
    end

    // R7 load error
    set_mark(8, 8'hFF); set_mark(9, 8'hFF);
    inj_op = 3'd0; inj_code = 4'd3;
    run(1'b0, mkrow(8), 1'b0);
    chk("R7", "load err code", int'(r_err), 3);
    chk("R7", "load err bad", int'(r_bad), 0);
    chk("R7", "load err reads", d_read, 0);
    chk("R7", "load err cycles", cyc, CMD_CYC + 1);
    // R7 read error
    inj_op = 3'd1; inj_code = 4'd9;
    run(1'b0, mkrow(8), 1'b0);
    chk("R7", "read err code", int'(r_err), 9);
    chk("R7", "read err loads", d_load, 1);
    chk("R7", "read err cycles", cyc, 2 * CMD_CYC + 1);
    // R6 erase error
    set_mark(12, 8'h77);
    inj_op = 3'd2; inj_code = 4'd5;
    run(1'b1, mkrow(12), 1'b0);
    chk("R6", "erase err code", int'(r_err), 5);
    chk("R6", "erase err bad", int'(r_bad), 0);
    chk("R6", "erase err pload", d_pload, 0);
    chk("R6", "erase err pexec", d_pexec, 0);
    chk("R6", "erase err cycles", cyc, CMD_CYC + 1);
    chk("R6", "marker untouched", int'(mk[12]), 8'h77);
    // R7 pload and pexec errors
    inj_op = 3'd3; inj_code = 4'hC;
    run(1'b1, mkrow(12), 1'b0);
    chk("R7", "pload err code", int'(r_err), 12);
    chk("R7", "pload err pexec", d_pexec, 0);
    chk("R7", "pload err cycles", cyc, 2 * CMD_CYC + 1);
    inj_op = 3'd4; inj_code = 4'hF;
    run(1'b1, mkrow(12), 1'b0);
    chk("R7", "pexec err code", int'(r_err), 15);
    chk("R7", "pexec err bad", int'(r_bad), 0);
    chk("R7", "pexec err cycles", cyc, 3 * CMD_CYC + 1);
    inj_code = 4'd0;

    // R8 mark request while busy is ignored
    set_mark(16, 8'hFF); set_mark(17, 8'hFF);
    run(1'b0, mkrow(16), 1'b1);
    chk("R8", "busy poke erase count", d_erase, 0);
    chk("R8", "busy poke bad", int'(r_bad), 0);
    chk("R8", "busy poke cycles", cyc, 4 * CMD_CYC + 1);
    // R8 simultaneous requests ignored
    begin
      int s_all;
      s_all = n_load + n_erase;
      @(negedge clk);
      chk_req = 1'b1; mark_req = 1'b1; row_in = mkrow(20);
      @(negedge clk);
      chk_req = 1'b0; mark_req = 1'b0;
      for (int k = 0; k < 4; k++) begin
        chk("R8", "dual request busy", int'(busy_o), 0);
        @(negedge clk);
      end
      chk("R8", "dual request commands", n_load + n_erase - s_all, 0);
      chk("R8", "dual request done", int'(done_o), 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule